// File: doc/BRIEF.md
# Reserved Command and Sleep Manager

This block sits beside the memory-access controller of a two-wire serial memory slave and handles the transactions that never touch the array. It receives the same byte-level events as the memory path: start or repeated start, stop, each received byte, and the SCL rising and falling edges with the sampled SDA value. It answers the reserved commands on its own. These commands are the high-speed mode prefix, a two-phase escape that leads either to a three-byte identification read or to sleep entry, and the wake-up sequence that begins partway through an address byte.

The escape works in two phases. The master sends the escape code 0xF8 as the first byte after a start. It then sends the device's own slave address, gives a repeated start, and follows with a second reserved code. That code is 0xF9 for identification or 0x86 for sleep. While asleep, the block watches the first six bits after each start. When they carry the device type code and the pin-strapped address, it begins a recovery period whose length is counted in system clocks. During that period it ignores stop conditions and gives no acknowledgement. A start followed by nine clocks with SDA high is a software reset, which returns all command state to idle.

Top module: `slp_manager`

## Requirements
- R1: A first byte after a start whose top five bits are 00001 is answered by a response pulse with `resp_ack_o` low (NACK). `hs_o` is high from the cycle after that byte.
- R2: `hs_o` stays high across further starts and bytes, and drops in the cycle after a stop.
- R3: The escape code 0xF8 as the first byte after a start is acknowledged. The next byte is acknowledged when bits 7:4 are 1010 and bits 3:2 equal `dev_addr_i` (bits 1:0 are don't-care). Any other next byte gets a NACK and the escape is abandoned.
- R4: After a repeated start, 0xF9 is acknowledged and `tx_act_o` rises. `tx_byte_o` then presents 0x01, 0xB0 and 0x00 in that order, which are a 12-bit manufacturer field 0x01B followed by a 12-bit type field 0x000. It advances on each `tx_next_i` and wraps to the first byte after the third.
- R5: After a repeated start, 0x86 is acknowledged. `sleep_o` rises in the cycle after the following stop, and not before.
- R6: After an accepted escape address, any byte other than 0xF9 or 0x86 following the repeated start gets a NACK and returns the block to idle. A byte arriving with no repeated start also gets a NACK. In both cases no mode changes.
- R7: While `sleep_o` is high, no received byte produces a response pulse. An address whose type code or pin bits do not match leaves the block asleep with `waking_o` low.
- R8: While asleep, a start followed by six bits 1010, A2, A1 that match `dev_addr_i` raises `waking_o` in the cycle after the sixth SCL falling edge. It stays high for exactly `REC_CYC` clock cycles, and a stop during that time does not end it.
- R9: When the recovery period ends, `sleep_o` and `waking_o` drop together and the escape sequence is acknowledged again.
- R10: While awake, a start followed by nine SCL rising edges all sampling SDA high returns the command state to idle and clears `hs_o`. If the ninth bit is low, it does not.
- R11: A first byte after a start that is neither the high-speed prefix nor 0xF8 produces no response pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start or repeated-start pulse |
| stop_i | input | 1 | Stop condition pulse |
| scl_rise_i | input | 1 | SCL rising-edge pulse; SDA sampled here |
| scl_fall_i | input | 1 | SCL falling-edge pulse |
| sda_i | input | 1 | SDA level, valid with `scl_rise_i` |
| byte_vld_i | input | 1 | A received byte is available |
| byte_i | input | 8 | Received byte, MSB first on the wire |
| tx_next_i | input | 1 | Master acknowledged a transmitted byte |
| dev_addr_i | input | 2 | Strapped address pins {A2, A1} |
| resp_vld_o | output | 1 | One-cycle pulse: this block answers the byte |
| resp_ack_o | output | 1 | With `resp_vld_o`: 1 = ACK, 0 = NACK |
| tx_act_o | output | 1 | Identification bytes are being sent |
| tx_byte_o | output | 8 | Current identification byte |
| hs_o | output | 1 | High-speed mode active |
| sleep_o | output | 1 | Sleeping, including recovery |
| waking_o | output | 1 | Recovery period running |

## Verification
The bench checks the sleep state against a stop that arrives during recovery. A design that honoured that stop would cut `waking_o` short, and the cycle count of the recovery window would show it. It sends wake addresses with wrong pin bits, which a design comparing only the type code would accept. It also sends a software reset whose ninth bit is low, which a design counting eight high bits would accept. It checks that 0x86 does not put the block to sleep before the stop and that a byte sent without a repeated start is refused. Random first bytes and random escape addresses are compared against bench decode functions, so a design that decoded the wrong prefix bits, or required the don't-care address bits, would show a mismatch.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ESC_ADDR, ST_ESC_RS, ST_ESC_CMD,
    ST_ID_TX, ST_SLP_PEND, ST_ASLEEP, ST_WAKING
  } mgr_state_e;

  localparam logic [7:0] ESC_CODE  = 8'hF8;
  localparam logic [7:0] ID_CODE   = 8'hF9;
  localparam logic [7:0] SLP_CODE  = 8'h86;
  localparam logic [3:0] TYPE_CODE = 4'hA;
  localparam logic [4:0] HS_PREFIX = 5'b00001;
  localparam int unsigned ADDR_BITS  = 6;  // type code plus two pin bits
  localparam int unsigned RESET_BITS = 9;  // high bits that form a software reset
endpackage

// File: rtl/slp_bitwatch.sv
module slp_bitwatch
  import slp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       sda_i,
  input  logic [1:0] dev_addr_i,
  output logic       swrst_o,
  output logic       wake_hit_o
);
  localparam int unsigned CW = $clog2(RESET_BITS + 2);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0]        cnt_q, cnt_d;
  logic                 ones_q, ones_d;
  logic [ADDR_BITS-1:0] sh_q, sh_d;

  always_comb begin
    cnt_d  = cnt_q;
    ones_d = ones_q;
    sh_d   = sh_q;
    if (start_i) begin
      cnt_d  = '0;
      ones_d = 1'b1;
    end else if (scl_rise_i) begin
      if (cnt_q != CMAX) cnt_d = cnt_q + 1'b1;
      ones_d = ones_q & sda_i;
      sh_d   = {sh_q[ADDR_BITS-2:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CMAX;
      ones_q <= 1'b0;
      sh_q   <= '0;
    end else begin
      cnt_q  <= cnt_d;
      ones_q <= ones_d;
      sh_q   <= sh_d;
    end
  end

  assign swrst_o    = scl_rise_i && !start_i && ones_q && sda_i &&
                      (cnt_q == CW'(RESET_BITS - 1));
  assign wake_hit_o = scl_fall_i && !start_i && (cnt_q == CW'(ADDR_BITS)) &&
                      (sh_q == {TYPE_CODE, dev_addr_i});
endmodule

// File: rtl/slp_rec_timer.sv
module slp_rec_timer #(
  parameter int unsigned REC_CYC = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(REC_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;

  assign done_o = run_q && (cnt_q == CW'(REC_CYC - 1));

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (go_i) begin
      cnt_d = '0;
      run_d = 1'b1;
    end else if (done_o) begin
      run_d = 1'b0;
    end else if (run_q) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end
endmodule

// File: rtl/slp_cmd_fsm.sv
module slp_cmd_fsm
  import slp_pkg::*;
#(
  parameter logic [11:0] MFR_ID   = 12'h01B,
  parameter logic [11:0] DEV_TYPE = 12'h000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       byte_vld_i,
  input  logic [7:0] byte_i,
  input  logic       tx_next_i,
  input  logic [1:0] dev_addr_i,
  input  logic       swrst_i,
  input  logic       wake_hit_i,
  input  logic       tmr_done_i,
  output logic       tmr_go_o,
  output logic       resp_vld_o,
  output logic       resp_ack_o,
  output logic       hs_o,
  output logic       sleep_o,
  output logic       waking_o,
  output logic       tx_act_o,
  output logic [7:0] tx_byte_o
);
  localparam logic [23:0] ID_WORD = {MFR_ID, DEV_TYPE};
  localparam int unsigned ID_LEN  = 3;

  mgr_state_e st_q, st_d;
  logic       first_q, first_d;
  logic       hs_q, hs_d;
  logic [1:0] idx_q, idx_d;
  logic       rv_q, rv_d, ra_q, ra_d;
  logic       addr_ok;

  assign addr_ok = (byte_i[7:4] == TYPE_CODE) && (byte_i[3:2] == dev_addr_i);

  always_comb begin
    st_d = st_q; first_d = first_q; hs_d = hs_q; idx_d = idx_q;
    rv_d = 1'b0; ra_d = 1'b0; tmr_go_o = 1'b0;
    case (st_q)
      ST_ASLEEP: if (wake_hit_i) begin
        st_d = ST_WAKING;
        tmr_go_o = 1'b1;
      end
      ST_WAKING: if (tmr_done_i) st_d = ST_IDLE;
      default: begin
        if (swrst_i) begin
          st_d = ST_IDLE; hs_d = 1'b0; first_d = 1'b0;
        end else if (stop_i) begin
          hs_d = 1'b0; first_d = 1'b0;
          st_d = (st_q == ST_SLP_PEND) ? ST_ASLEEP : ST_IDLE;
        end else if (start_i) begin
          first_d = 1'b1;
          st_d = (st_q == ST_ESC_RS) ? ST_ESC_CMD : ST_IDLE;
        end else if (byte_vld_i) begin
          first_d = 1'b0;
          case (st_q)
            ST_IDLE: if (first_q) begin
              if (byte_i[7:3] == HS_PREFIX) begin
                hs_d = 1'b1; rv_d = 1'b1;
              end else if (byte_i == ESC_CODE) begin
                rv_d = 1'b1; ra_d = 1'b1; st_d = ST_ESC_ADDR;
              end
            end
            ST_ESC_ADDR: begin
              rv_d = 1'b1; ra_d = addr_ok;
              st_d = addr_ok ? ST_ESC_RS : ST_IDLE;
            end
            ST_ESC_CMD: begin
              rv_d = 1'b1;
              if (byte_i == ID_CODE) begin
                ra_d = 1'b1; idx_d = '0; st_d = ST_ID_TX;
              end else if (byte_i == SLP_CODE) begin
                ra_d = 1'b1; st_d = ST_SLP_PEND;
              end else begin
                st_d = ST_IDLE;
              end
            end
            ST_ID_TX: ;
            default: begin
              rv_d = 1'b1; st_d = ST_IDLE;
            end
          endcase
        end else if (tx_next_i && st_q == ST_ID_TX) begin
          idx_d = (idx_q == 2'(ID_LEN - 1)) ? 2'd0 : idx_q + 2'd1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; first_q <= 1'b0; hs_q <= 1'b0; idx_q <= '0;
      rv_q <= 1'b0; ra_q <= 1'b0;
    end else begin
      st_q <= st_d; first_q <= first_d; hs_q <= hs_d; idx_q <= idx_d;
      rv_q <= rv_d; ra_q <= ra_d;
    end
  end

  always_comb begin
    case (idx_q)
      2'd0:    tx_byte_o = ID_WORD[23:16];
      2'd1:    tx_byte_o = ID_WORD[15:8];
      default: tx_byte_o = ID_WORD[7:0];
    endcase
  end

  assign resp_vld_o = rv_q;
  assign resp_ack_o = ra_q;
  assign hs_o       = hs_q;
  assign sleep_o    = (st_q == ST_ASLEEP) || (st_q == ST_WAKING);
  assign waking_o   = (st_q == ST_WAKING);
  assign tx_act_o   = (st_q == ST_ID_TX);

  // R1
  hs_rise_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_o) |-> (resp_vld_o && !resp_ack_o))
    else $error("hs_o rose without a NACK response");
  // R2
  hs_stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !hs_o)
    else $error("hs_o survived a stop");
  // R7
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_o |-> !resp_vld_o)
    else $error("response given while asleep");
  // R8
  wake_stop_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (waking_o && stop_i && !tmr_done_i) |=> waking_o)
    else $error("stop ended the recovery period");
  // R4
  id_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_act_o && tx_next_i && !start_i && !stop_i && !swrst_i && !byte_vld_i)
      |=> (tx_byte_o != $past(tx_byte_o)))
    else $error("identification byte did not advance");
endmodule

// File: rtl/slp_manager.sv
module slp_manager #(
  parameter int unsigned REC_CYC  = 10000,
  parameter logic [11:0] MFR_ID   = 12'h01B,
  parameter logic [11:0] DEV_TYPE = 12'h000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       sda_i,
  input  logic       byte_vld_i,
  input  logic [7:0] byte_i,
  input  logic       tx_next_i,
  input  logic [1:0] dev_addr_i,
  output logic       resp_vld_o,
  output logic       resp_ack_o,
  output logic       tx_act_o,
  output logic [7:0] tx_byte_o,
  output logic       hs_o,
  output logic       sleep_o,
  output logic       waking_o
);
  logic swrst, wake_hit, tmr_go, tmr_done;

  slp_bitwatch u_watch (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .scl_rise_i(scl_rise_i),
    .scl_fall_i(scl_fall_i), .sda_i(sda_i), .dev_addr_i(dev_addr_i),
    .swrst_o(swrst), .wake_hit_o(wake_hit)
  );

  slp_rec_timer #(.REC_CYC(REC_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .go_i(tmr_go), .done_o(tmr_done)
  );

  slp_cmd_fsm #(.MFR_ID(MFR_ID), .DEV_TYPE(DEV_TYPE)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .tx_next_i(tx_next_i),
    .dev_addr_i(dev_addr_i), .swrst_i(swrst), .wake_hit_i(wake_hit),
    .tmr_done_i(tmr_done), .tmr_go_o(tmr_go), .resp_vld_o(resp_vld_o),
    .resp_ack_o(resp_ack_o), .hs_o(hs_o), .sleep_o(sleep_o),
    .waking_o(waking_o), .tx_act_o(tx_act_o), .tx_byte_o(tx_byte_o)
  );

  // R9
  waking_in_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    waking_o |-> sleep_o)
    else $error("waking_o high outside sleep");
  // R8
  wake_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(waking_o) |-> $past(scl_fall_i))
    else $error("recovery began away from an SCL falling edge");
endmodule

// File: tb/tb_slp_manager.sv
module tb_slp_manager;
  localparam int unsigned REC = 40;
  localparam logic [1:0] DEV = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 0, stop_i = 0, scl_rise_i = 0, scl_fall_i = 0, sda_i = 1;
  logic byte_vld_i = 0, tx_next_i = 0;
  logic [7:0] byte_i = '0;
  logic resp_vld_o, resp_ack_o, tx_act_o, hs_o, sleep_o, waking_o;
  logic [7:0] tx_byte_o;

  int n_chk = 0, n_fail = 0, wake_len = 0;
  logic got_vld, got_ack;

  always #5 clk = ~clk;

  slp_manager #(.REC_CYC(REC)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .scl_rise_i(scl_rise_i), .scl_fall_i(scl_fall_i), .sda_i(sda_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .tx_next_i(tx_next_i),
    .dev_addr_i(DEV), .resp_vld_o(resp_vld_o), .resp_ack_o(resp_ack_o),
    .tx_act_o(tx_act_o), .tx_byte_o(tx_byte_o), .hs_o(hs_o),
    .sleep_o(sleep_o), .waking_o(waking_o)
  );

  always @(posedge clk) if (waking_o) wake_len <= wake_len + 1;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
  endtask

  task automatic do_stop();
    @(negedge clk) stop_i = 1;
    @(negedge clk) stop_i = 0;
  endtask

  task automatic clk_bit(logic v);
    @(negedge clk) begin sda_i = v; scl_rise_i = 1; end
    @(negedge clk) begin scl_rise_i = 0; scl_fall_i = 1; end
    @(negedge clk) scl_fall_i = 0;
  endtask

  // eight data bits, byte event, response sample, ninth bit
  task automatic send_byte(logic [7:0] b, logic ninth = 1'b0);
    for (int i = 7; i >= 0; i--) clk_bit(b[i]);
    @(negedge clk) begin byte_vld_i = 1; byte_i = b; end
    @(negedge clk) begin
      byte_vld_i = 0;
      got_vld = resp_vld_o;
      got_ack = resp_ack_o;
    end
    clk_bit(ninth);
    @(negedge clk) sda_i = 1;
  endtask

  task automatic pulse_next();
    @(negedge clk) tx_next_i = 1;
    @(negedge clk) tx_next_i = 0;
  endtask

  // expected {vld, ack} for a first byte after a start
  function automatic logic [1:0] exp_first(logic [7:0] b);
    if (b[7:3] == 5'b00001) return 2'b10;
    if (b == 8'hF8) return 2'b11;
    return 2'b00;
  endfunction

  function automatic logic exp_addr(logic [7:0] a);
    return (a[7:4] == 4'hA) && (a[3:2] == DEV);
  endfunction

  task automatic escape_prefix();
    do_start();
    send_byte(8'hF8);
    chk("R3 escape ack", {got_vld, got_ack}, 2'b11);
    send_byte({4'hA, DEV, 2'b01});
    chk("R3 address ack", {got_vld, got_ack}, 2'b11);
  endtask

  initial begin
    int w0;
    logic [7:0] b, a;
    logic [1:0] e;
    b = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    chk("reset resp", resp_vld_o, 0);
    chk("reset sleep", {sleep_o, waking_o, hs_o, tx_act_o}, 0);
    @(negedge clk) rst_n = 1;
    repeat (2) @(negedge clk);

    // R1 / R2 high-speed prefix
    do_start();
    send_byte(8'h0D);
    chk("R1 hs nack", {got_vld, got_ack}, 2'b10);
    chk("R1 hs set", hs_o, 1);
    do_start();
    send_byte(8'hA0);
    chk("R11 normal address no resp", got_vld, 0);
    chk("R2 hs held across start", hs_o, 1);
    do_stop();
    chk("R2 hs cleared by stop", hs_o, 0);

    // R10 software reset vs. ninth bit low
    do_start(); send_byte(8'h08);
    do_start(); send_byte(8'hFF, 1'b0);
    chk("R10 ninth low keeps hs", hs_o, 1);
    do_start(); send_byte(8'hFF, 1'b1);
    chk("R10 nine high bits clear hs", hs_o, 0);
    escape_prefix();
    do_start(); send_byte(8'hFF, 1'b1);
    do_start(); send_byte(8'hF9);
    chk("R10 reset returns escape to idle", {got_vld, tx_act_o}, 0);
    do_stop();

    // R3 mismatched address
    do_start(); send_byte(8'hF8);
    send_byte({4'hA, ~DEV, 2'b00});
    chk("R3 wrong pins nack", {got_vld, got_ack}, 2'b10);
    do_start(); send_byte(8'h86);
    chk("R3 back to idle", got_vld, 0);
    do_stop();

    // R6 unexpected codes
    escape_prefix();
    do_start(); send_byte(8'h55);
    chk("R6 bad code nack", {got_vld, got_ack}, 2'b10);
    do_stop();
    chk("R6 no sleep", sleep_o, 0);
    escape_prefix();
    send_byte(8'hF9);
    chk("R6 no repeated start nack", {got_vld, got_ack, tx_act_o}, 3'b100);
    do_stop();

    // R4 identification read
    escape_prefix();
    do_start(); send_byte(8'hF9);
    chk("R4 id ack", {got_vld, got_ack}, 2'b11);
    chk("R4 tx active", tx_act_o, 1);
    chk("R4 byte0", tx_byte_o, 8'h01);
    pulse_next(); @(negedge clk);
    chk("R4 byte1", tx_byte_o, 8'hB0);
    pulse_next(); @(negedge clk);
    chk("R4 byte2", tx_byte_o, 8'h00);
    pulse_next(); @(negedge clk);
    chk("R4 wrap", tx_byte_o, 8'h01);
    do_stop();
    chk("R4 tx ends at stop", tx_act_o, 0);

    // random first bytes and escape addresses
    for (int k = 0; k < 40; k++) begin
      b = $urandom();
      if (k % 4 == 0) b = 8'hF8;
      if (k % 4 == 1) b = {5'b00001, 3'($urandom())};
      e = exp_first(b);
      do_start(); send_byte(b);
      chk("R11 R1 R3 random first byte", {got_vld, got_ack}, e);
      if (b == 8'hF8) begin
        a = $urandom();
        if (k % 8 == 0) a[7:2] = {4'hA, DEV};
        send_byte(a);
        chk("R3 random address", {got_vld, got_ack}, {1'b1, exp_addr(a)});
      end
      do_stop();
      chk("R2 random hs clear", hs_o, 0);
    end

    // R5 sleep entry
    escape_prefix();
    do_start(); send_byte(8'h86);
    chk("R5 sleep ack", {got_vld, got_ack}, 2'b11);
    chk("R5 not asleep before stop", sleep_o, 0);
    do_stop();
    chk("R5 asleep after stop", sleep_o, 1);

    // R7 ignored while asleep
    do_start(); send_byte(8'hF8);
    chk("R7 no response asleep", got_vld, 0);
    do_stop();
    do_start(); send_byte({4'hA, ~DEV, 2'b00});
    chk("R7 wrong pins stay asleep", {sleep_o, waking_o, got_vld}, 3'b100);
    do_stop();
    do_start(); send_byte({4'h5, DEV, 2'b00});
    chk("R7 wrong type stays asleep", {sleep_o, waking_o}, 2'b10);
    do_stop();

    // R8 wake-up
    w0 = wake_len;
    do_start();
    for (int i = 5; i >= 0; i--) clk_bit(i >= 2 ? ((4'hA >> (i - 2)) & 1) : DEV[i]);
    chk("R8 waking after sixth fall", waking_o, 1);
    clk_bit(0); clk_bit(0);
    do_stop();
    chk("R8 stop ignored", waking_o, 1);
    chk("R7 no ack while waking", resp_vld_o, 0);
    repeat (REC + 5) @(negedge clk);
    chk("R8 recovery length", wake_len - w0, REC);
    chk("R9 awake", {sleep_o, waking_o}, 0);
    escape_prefix();
    do_stop();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule